// File: doc/BRIEF.md
# Six-Read Unlock Sequence Detector

This block sits beside a memory's host port and watches the read traffic going to it. It is looking for one exact chain of six consecutive read addresses. The first five addresses are fixed. The sixth address decides which command is raised: one value asks for a save of the memory into its nonvolatile shadow, and another asks for a restore from that shadow. Every read in the chain is still served normally by the memory. The detector only observes the traffic and never stalls or blocks it.

When the chain completes, the block emits a single-clock command pulse. At the same moment it raises a flag that tells the data path to float its output drivers. That flag stays up while the external engine reports that it is busy. If the engine never signals busy, the flag drops after a bounded wait. While the engine is busy, or while the flag is up, no new chain can begin.

A read is counted on the rising edge of the read strobe, but only while the chip select is low and the write enable is high. A write aborts the chain, and so does any read whose address is out of order. The output-enable pin plays no part in triggering and is not an input to the block.

Top module: `nv_unlock_seq`

## Requirements
- R1: After reset, `store_cmd`, `recall_cmd` and `out_hiz` are all low.
- R2: The reads 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order, raise `store_cmd` for exactly one clock. The pulse starts on the clock edge that samples the last strobe rise.
- R3: The same five-read prefix followed by 0x0F0E raises `recall_cmd` for exactly one clock. `store_cmd` stays low during that sequence.
- R4: A read whose address does not match the expected step returns the matcher to its start. A later completion of the remaining steps then produces no command.
- R5: A mismatching read at address 0x0000 counts as step one of a new chain. The series 0x0000, 0x1555, 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F therefore produces a store command.
- R6: Any clock edge that samples chip select low together with write enable low aborts the chain in progress.
- R7: Strobe activity while chip select is high is ignored. Such activity neither advances nor aborts the chain.
- R8: A read strobe held high for several clocks counts as a single read.
- R9: `out_hiz` rises together with either command pulse. It then stays high until the clock edge after `nv_busy` is seen low, once `nv_busy` has been seen high.
- R10: While `nv_busy` or `out_hiz` is high, reads are not counted and any partial chain is discarded.
- R11: If `nv_busy` does not rise within WAIT_LIM clocks after a command, `out_hiz` drops.
- R12: A sixth read that matches neither final address produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 13 | Host access address |
| rd_strobe | input | 1 | Read strobe; its rising edge marks a read |
| chip_sel_n | input | 1 | Chip select, active low |
| wr_en_n | input | 1 | Write enable, active low (high means read) |
| nv_busy | input | 1 | High while the nonvolatile engine is working |
| store_cmd | output | 1 | One-clock save request |
| recall_cmd | output | 1 | One-clock restore request |
| out_hiz | output | 1 | Asks the data path to float its outputs |

## Verification
On every cycle, assertions check several properties. Each command pulse lasts one clock, and the two commands never fire together. The float flag is up whenever a command fires. No command follows a cycle in which the block was inhibited. A write always empties the matcher. The flag only falls while busy is low.

The ordering rules can only be shown by the directed scenarios. These cover exact-order completion, restart on 0x0000, aborts caused by mismatches and writes, and single counting of a held strobe. The scenarios also cover indifference to deselected strobes, discarding of partial chains across a busy period, and the release of the flag after the wait limit.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
    localparam int ADDR_W = 13;
    localparam int STEPS  = 6;
    localparam int STEP_W = $clog2(STEPS);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {CMD_NONE, CMD_STORE, CMD_RECALL} cmd_e;
    typedef enum logic [1:0] {HZ_IDLE, HZ_WAIT, HZ_RUN} hz_e;

    localparam addr_t STORE_TAIL  = 13'h0F0F;
    localparam addr_t RECALL_TAIL = 13'h0F0E;

    // fixed prefix of the unlock chain, indexed by step
    function automatic addr_t key_addr(input step_t idx);
        case (idx)
            step_t'(0): key_addr = 13'h0000;
            step_t'(1): key_addr = 13'h1555;
            step_t'(2): key_addr = 13'h0AAA;
            step_t'(3): key_addr = 13'h1FFF;
            default:    key_addr = 13'h10F0;
        endcase
    endfunction
endpackage

// File: rtl/nvu_access_decode.sv
module nvu_access_decode (
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe,
    input  logic chip_sel_n,
    input  logic wr_en_n,
    output logic rd_evt,
    output logic wr_evt
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= rd_strobe;
    end

    assign rd_evt = rd_strobe & ~strobe_q & ~chip_sel_n & wr_en_n;
    assign wr_evt = ~chip_sel_n & ~wr_en_n;

    a_r8_single_count: assert property (@(posedge clk) disable iff (rst)
        rd_evt |=> !rd_evt);
endmodule

// File: rtl/nvu_matcher.sv
module nvu_matcher
    import nvu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_evt,
    input  logic  wr_evt,
    input  logic  inhibit,
    input  addr_t addr,
    output cmd_e  fire,
    output logic  store_q,
    output logic  recall_q
);
    localparam step_t LAST = step_t'(STEPS - 1);

    step_t step_q, step_d;
    logic  is_head;

    assign is_head = (addr == key_addr(step_t'(0)));

    always_comb begin
        step_d = step_q;
        fire   = CMD_NONE;
        if (inhibit || wr_evt) begin
            step_d = '0;
        end else if (rd_evt) begin
            if (step_q == LAST) begin
                if (addr == STORE_TAIL)       fire = CMD_STORE;
                else if (addr == RECALL_TAIL) fire = CMD_RECALL;
                if (fire == CMD_NONE && is_head) step_d = step_t'(1);
                else                             step_d = '0;
            end else if (addr == key_addr(step_q)) begin
                step_d = step_q + step_t'(1);
            end else begin
                step_d = is_head ? step_t'(1) : step_t'(0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= '0;
            store_q  <= 1'b0;
            recall_q <= 1'b0;
        end else begin
            step_q   <= step_d;
            store_q  <= (fire == CMD_STORE);
            recall_q <= (fire == CMD_RECALL);
        end
    end

    a_r2_store_one_clk: assert property (@(posedge clk) disable iff (rst)
        store_q |=> !store_q);
    a_r3_recall_one_clk: assert property (@(posedge clk) disable iff (rst)
        recall_q |=> !recall_q);
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(store_q && recall_q));
    a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> (step_q == '0));
    a_r10_no_cmd_inhibit: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> !(store_q || recall_q));
    a_r4_step_bound: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST);
endmodule

// File: rtl/nvu_hiz_ctrl.sv
module nvu_hiz_ctrl
    import nvu_pkg::*;
#(
    parameter int WAIT_LIM = 16
) (
    input  logic clk,
    input  logic rst,
    input  cmd_e fire,
    input  logic nv_busy,
    output logic hiz
);
    localparam int CNT_W = $clog2(WAIT_LIM + 1);

    hz_e              st_q;
    logic [CNT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HZ_IDLE;
            wait_q <= '0;
        end else begin
            case (st_q)
                HZ_IDLE: if (fire != CMD_NONE) begin
                    st_q   <= HZ_WAIT;
                    wait_q <= '0;
                end
                HZ_WAIT: begin
                    if (nv_busy)                              st_q <= HZ_RUN;
                    else if (wait_q == CNT_W'(WAIT_LIM - 1))  st_q <= HZ_IDLE;
                    wait_q <= wait_q + CNT_W'(1);
                end
                HZ_RUN:  if (!nv_busy) st_q <= HZ_IDLE;
                default: st_q <= HZ_IDLE;
            endcase
        end
    end

    assign hiz = (st_q != HZ_IDLE);

    a_r9_release_idle: assert property (@(posedge clk) disable iff (rst)
        (hiz && $past(nv_busy) && nv_busy) |=> hiz);
    a_r11_wait_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == HZ_WAIT) |-> (wait_q < CNT_W'(WAIT_LIM)));
endmodule

// File: rtl/nv_unlock_seq.sv
module nv_unlock_seq
    import nvu_pkg::*;
#(
    parameter int WAIT_LIM = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              rd_strobe,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              nv_busy,
    output logic              store_cmd,
    output logic              recall_cmd,
    output logic              out_hiz
);
    logic rd_evt, wr_evt;
    cmd_e fire;

    nvu_access_decode u_dec (
        .clk(clk), .rst(rst), .rd_strobe(rd_strobe),
        .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .rd_evt(rd_evt), .wr_evt(wr_evt)
    );

    nvu_matcher u_match (
        .clk(clk), .rst(rst), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .inhibit(nv_busy | out_hiz), .addr(acc_addr), .fire(fire),
        .store_q(store_cmd), .recall_q(recall_cmd)
    );

    nvu_hiz_ctrl #(.WAIT_LIM(WAIT_LIM)) u_hiz (
        .clk(clk), .rst(rst), .fire(fire), .nv_busy(nv_busy), .hiz(out_hiz)
    );

    a_r9_hiz_with_cmd: assert property (@(posedge clk) disable iff (rst)
        (store_cmd || recall_cmd) |-> out_hiz);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !(store_cmd || recall_cmd || out_hiz));
endmodule

// File: tb/nv_unlock_seq_tb.sv
module nv_unlock_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] acc_addr = '0;
    logic        rd_strobe = 1'b0, chip_sel_n = 1'b1, wr_en_n = 1'b1, nv_busy = 1'b0;
    logic        store_cmd, recall_cmd, out_hiz;
    int          n_chk = 0, n_fail = 0;

    localparam int WLIM = 16;

    always #2 clk = ~clk;

    nv_unlock_seq #(.WAIT_LIM(WLIM)) u_dut (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .rd_strobe(rd_strobe),
        .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n), .nv_busy(nv_busy),
        .store_cmd(store_cmd), .recall_cmd(recall_cmd), .out_hiz(out_hiz)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one read: strobe high for 'hold' clocks; returns cmd flags seen after first edge
    task automatic rd(input logic [12:0] a, input int hold, output logic st, output logic rc);
        @(negedge clk);
        acc_addr = a; chip_sel_n = 1'b0; wr_en_n = 1'b1; rd_strobe = 1'b1;
        @(negedge clk);
        st = store_cmd; rc = recall_cmd;
        for (int i = 1; i < hold; i++) @(negedge clk);
        rd_strobe = 1'b0; chip_sel_n = 1'b1;
    endtask

    task automatic rd_seq(input logic [12:0] tail, output logic st, output logic rc);
        logic s, r;
        rd(13'h0000, 1, s, r); rd(13'h1555, 1, s, r); rd(13'h0AAA, 1, s, r);
        rd(13'h1FFF, 1, s, r); rd(13'h10F0, 1, s, r); rd(tail, 1, st, rc);
    endtask

    task automatic settle();
        repeat (WLIM + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 store", store_cmd, 1'b0);
        check("R1 recall", recall_cmd, 1'b0);
        check("R1 hiz", out_hiz, 1'b0);
    endtask

    task automatic t_store();
        logic s, r;
        rd_seq(13'h0F0F, s, r);
        check("R2 store pulse", s, 1'b1);
        check("R2 no recall", r, 1'b0);
        check("R9 hiz with cmd", out_hiz, 1'b1);
        @(negedge clk);
        check("R2 one clock", store_cmd, 1'b0);
        nv_busy = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 hiz held busy", out_hiz, 1'b1);
        nv_busy = 1'b0;
        @(negedge clk);
        check("R9 hiz released", out_hiz, 1'b0);
        settle();
    endtask

    task automatic t_recall();
        logic s, r;
        rd_seq(13'h0F0E, s, r);
        check("R3 recall pulse", r, 1'b1);
        check("R3 no store", s, 1'b0);
        @(negedge clk);
        check("R3 one clock", recall_cmd, 1'b0);
        repeat (WLIM + 2) @(negedge clk);
        check("R11 hiz timeout", out_hiz, 1'b0);
        settle();
    endtask

    task automatic t_mismatch();
        logic s, r;
        rd(13'h0000, 1, s, r); rd(13'h1555, 1, s, r); rd(13'h0123, 1, s, r);
        rd(13'h0AAA, 1, s, r); rd(13'h1FFF, 1, s, r); rd(13'h10F0, 1, s, r);
        rd(13'h0F0F, 1, s, r);
        check("R4 abort on mismatch", s, 1'b0);
        settle();
    endtask

    task automatic t_restart();
        logic s, r;
        rd(13'h0000, 1, s, r); rd(13'h1555, 1, s, r);
        rd_seq(13'h0F0F, s, r);
        check("R5 restart at head", s, 1'b1);
        settle();
    endtask

    task automatic t_write();
        logic s, r;
        rd(13'h0000, 1, s, r); rd(13'h1555, 1, s, r); rd(13'h0AAA, 1, s, r);
        @(negedge clk); chip_sel_n = 1'b0; wr_en_n = 1'b0; acc_addr = 13'h0AAA;
        @(negedge clk); chip_sel_n = 1'b1; wr_en_n = 1'b1;
        rd(13'h1FFF, 1, s, r); rd(13'h10F0, 1, s, r); rd(13'h0F0F, 1, s, r);
        check("R6 write aborts", s, 1'b0);
        settle();
    endtask

    task automatic t_deselect();
        logic s, r;
        rd(13'h0000, 1, s, r); rd(13'h1555, 1, s, r);
        @(negedge clk); acc_addr = 13'h0777; rd_strobe = 1'b1; chip_sel_n = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        rd(13'h0AAA, 1, s, r); rd(13'h1FFF, 1, s, r); rd(13'h10F0, 1, s, r);
        rd(13'h0F0F, 1, s, r);
        check("R7 deselected ignored", s, 1'b1);
        settle();
    endtask

    task automatic t_hold();
        logic s, r;
        rd(13'h0000, 1, s, r); rd(13'h1555, 4, s, r); rd(13'h0AAA, 1, s, r);
        rd(13'h1FFF, 1, s, r); rd(13'h10F0, 1, s, r); rd(13'h0F0E, 1, s, r);
        check("R8 held strobe once", r, 1'b1);
        settle();
    endtask

    task automatic t_busy();
        logic s, r;
        nv_busy = 1'b1;
        rd_seq(13'h0F0F, s, r);
        check("R10 no cmd while busy", s, 1'b0);
        check("R10 hiz not self-raised", out_hiz, 1'b0);
        nv_busy = 1'b0;
        rd(13'h0000, 1, s, r); rd(13'h1555, 1, s, r); rd(13'h0AAA, 1, s, r);
        @(negedge clk); nv_busy = 1'b1;
        @(negedge clk); nv_busy = 1'b0;
        rd(13'h1FFF, 1, s, r); rd(13'h10F0, 1, s, r); rd(13'h0F0F, 1, s, r);
        check("R10 partial chain dropped", s, 1'b0);
        settle();
    endtask

    task automatic t_badtail();
        logic s, r;
        rd_seq(13'h0F0D, s, r);
        check("R12 store low", s, 1'b0);
        check("R12 recall low", r, 1'b0);
        check("R12 hiz low", out_hiz, 1'b0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset(); t_store(); t_recall(); t_mismatch(); t_restart();
        t_write(); t_deselect(); t_hold(); t_busy(); t_badtail();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule